// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable counter of a processor performance-monitoring unit. In each cycle it receives a small set of event lanes from the local logical processor and a matching set from a sibling logical processor in the same package. Each lane carries a valid bit, an 8-bit event code and an 8-bit sub-condition mask. A 32-bit control word chooses which event code and sub-conditions are of interest. The lanes that match are counted, and that per-cycle count passes through a threshold comparator with an optional inverted sense, an optional rising-edge detector and a privilege-level gate. The result is added to a 48-bit accumulator.

Software writes the control word and the count. It reads both back. When the accumulator wraps past its top value, a sticky overflow flag is set, and an interrupt line follows that flag while interrupts are enabled in the control word. The event-producing pipeline, chaining of counters, precise sampling and fixed-function counters all sit outside this block.

Top module: `qual_evt_counter`

## Requirements
- R1: A local lane matches when its valid bit is 1, its event code equals control bits [7:0], and its mask ANDed with control bits [15:8] is nonzero. The per-cycle count n is the number of matching lanes, from 0 to 4.
- R2: With the threshold field (control bits [31:24]) at zero, each cycle adds n to the count.
- R3: With a nonzero threshold and the invert bit (control bit 22) clear, a cycle adds 1 when n is at least the threshold and adds 0 otherwise.
- R4: With a nonzero threshold and the invert bit set, a cycle adds 1 when n is below the threshold. With a zero threshold, the invert bit has no effect.
- R5: With the edge bit (control bit 18) set, the count rises by 1 only in a cycle where the qualified condition is true and was false in the cycle before. A condition that stays true adds nothing more.
- R6: At privilege level 0, counting needs the kernel-enable bit (control bit 17). At levels 1, 2 and 3, counting needs the user-enable bit (control bit 16). With both bits clear, nothing is counted.
- R7: With the any-thread bit (control bit 19) set, a lane position counts when either the local lane or the sibling lane at that position matches. With the bit clear, sibling lanes are ignored.
- R8: With the global enable bit (control bit 21) clear, the count does not change on its own.
- R9: A count write takes priority over any increment in the same cycle, loads the written value, and clears the overflow flag.
- R10: The count is 48 bits wide and wraps modulo 2^48. A wrap sets a sticky overflow flag. The interrupt output is high while that flag is set and the interrupt-enable bit (control bit 20) is set.
- R11: The control word reads back as it was written, except that bit 23 is reserved and always reads 0.
- R12: After reset, the count, the overflow flag, the interrupt output and the control word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 48 | Count write data |
| loc_vld | input | 4 | Local lane valid bits |
| loc_code | input | 32 | Local lane event codes, 8 bits per lane |
| loc_mask | input | 32 | Local lane sub-condition masks, 8 bits per lane |
| sib_vld | input | 4 | Sibling lane valid bits |
| sib_code | input | 32 | Sibling lane event codes, 8 bits per lane |
| sib_mask | input | 32 | Sibling lane sub-condition masks, 8 bits per lane |
| priv_lvl | input | 2 | Current privilege level |
| cnt_rdata | output | 48 | Current count |
| ctrl_rdata | output | 32 | Current control word |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The main sweep goes through every local match pattern across thresholds 0 to 5 with the invert bit both clear and set. Each non-matching lane fails in one of three ways: it is invalid, its code is wrong, or its mask is disjoint. This separates raw counting, the at-or-above compare and the below compare, and it shows whether any single match condition has been dropped. A second sweep pairs every local pattern with every sibling pattern under the any-thread bit, which tells an OR of lane positions apart from a sum of both sides. The remaining tests cover the privilege gate at all four levels, a held condition and a re-raised condition under edge mode, a write that collides with an increment, and a wrap near the top of the range with the interrupt enabled and disabled.

// File: rtl/qec_pkg.sv
package qec_pkg;

    localparam int CODE_W = 8;
    localparam int MASK_W = 8;
    localparam int THR_W  = 8;
    localparam int CTRL_W = 32;

    typedef struct packed {
        logic [THR_W-1:0]  thresh;
        logic              rsvd;
        logic              invert;
        logic              enable;
        logic              int_en;
        logic              any_thr;
        logic              edge_md;
        logic              kern_en;
        logic              user_en;
        logic [MASK_W-1:0] sel_mask;
        logic [CODE_W-1:0] sel_code;
    } ctrl_t;

    function automatic logic priv_allowed(input ctrl_t c, input logic [1:0] lvl);
        return (lvl == 2'd0) ? c.kern_en : c.user_en;
    endfunction

endpackage

// File: rtl/qec_match.sv
module qec_match
    import qec_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int N_W = $clog2(NUM_LANES + 1)
) (
    input  ctrl_t                        ctrl,
    input  logic [NUM_LANES-1:0]         loc_vld,
    input  logic [NUM_LANES*CODE_W-1:0]  loc_code,
    input  logic [NUM_LANES*MASK_W-1:0]  loc_mask,
    input  logic [NUM_LANES-1:0]         sib_vld,
    input  logic [NUM_LANES*CODE_W-1:0]  sib_code,
    input  logic [NUM_LANES*MASK_W-1:0]  sib_mask,
    output logic [N_W-1:0]               n_sel
);

    logic [NUM_LANES-1:0] hit;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic loc_hit;
        logic sib_hit;
        assign loc_hit = loc_vld[i]
                       && (loc_code[i*CODE_W +: CODE_W] == ctrl.sel_code)
                       && ((loc_mask[i*MASK_W +: MASK_W] & ctrl.sel_mask) != '0);
        assign sib_hit = sib_vld[i]
                       && (sib_code[i*CODE_W +: CODE_W] == ctrl.sel_code)
                       && ((sib_mask[i*MASK_W +: MASK_W] & ctrl.sel_mask) != '0);
        assign hit[i] = loc_hit || (ctrl.any_thr && sib_hit);
    end

    always_comb begin
        n_sel = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            n_sel = n_sel + N_W'(hit[i]);
        end
    end

endmodule

// File: rtl/qec_qualify.sv
module qec_qualify
    import qec_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int N_W = $clog2(NUM_LANES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [1:0]     priv_lvl,
    input  logic [N_W-1:0] n_sel,
    output logic [N_W-1:0] inc
);

    logic             gate;
    logic             cond;
    logic             qcond;
    logic             prev_q;
    logic [THR_W-1:0] n_ext;
    logic [N_W-1:0]   level_inc;

    assign n_ext = THR_W'(n_sel);
    assign gate  = ctrl.enable && priv_allowed(ctrl, priv_lvl);

    always_comb begin
        if (ctrl.thresh == '0) begin
            cond = (n_sel != '0);
        end else if (ctrl.invert) begin
            cond = (n_ext < ctrl.thresh);
        end else begin
            cond = (n_ext >= ctrl.thresh);
        end
    end

    assign qcond     = gate && cond;
    assign level_inc = (ctrl.thresh == '0) ? n_sel : N_W'(cond);

    always_comb begin
        if (!gate) begin
            inc = '0;
        end else if (ctrl.edge_md) begin
            inc = N_W'(qcond && !prev_q);
        end else begin
            inc = level_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= qcond;
        end
    end

    a_r5_edge_single: assert property (@(posedge clk) disable iff (rst)
        (ctrl.edge_md && inc != '0) |-> (inc == N_W'(1) && !prev_q));

    a_r2_inc_bound: assert property (@(posedge clk) disable iff (rst)
        inc <= N_W'(NUM_LANES));

endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
    parameter int CNT_W = 48,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W:0] sum;

    assign sum = {1'b0, count} + (CNT_W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr_en) begin
            count <= wr_data;
            ovf   <= 1'b0;
        end else if (inc != '0) begin
            count <= sum[CNT_W-1:0];
            if (sum[CNT_W]) begin
                ovf <= 1'b1;
            end
        end
    end

    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data) && !ovf));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !wr_en) |=> ovf);

    a_r10_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && inc != '0 && count > ({CNT_W{1'b1}} - CNT_W'(inc))) |=> ovf);

endmodule

// File: rtl/qual_evt_counter.sv
module qual_evt_counter
    import qec_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 48,
    localparam int N_W = $clog2(NUM_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctrl_we,
    input  logic [CTRL_W-1:0]           ctrl_wdata,
    input  logic                        cnt_we,
    input  logic [CNT_W-1:0]            cnt_wdata,
    input  logic [NUM_LANES-1:0]        loc_vld,
    input  logic [NUM_LANES*CODE_W-1:0] loc_code,
    input  logic [NUM_LANES*MASK_W-1:0] loc_mask,
    input  logic [NUM_LANES-1:0]        sib_vld,
    input  logic [NUM_LANES*CODE_W-1:0] sib_code,
    input  logic [NUM_LANES*MASK_W-1:0] sib_mask,
    input  logic [1:0]                  priv_lvl,
    output logic [CNT_W-1:0]            cnt_rdata,
    output logic [CTRL_W-1:0]           ctrl_rdata,
    output logic                        ovf_flag,
    output logic                        irq
);

    ctrl_t          ctrl_q;
    ctrl_t          ctrl_in;
    logic [N_W-1:0] n_sel;
    logic [N_W-1:0] inc;

    always_comb begin
        ctrl_in      = ctrl_t'(ctrl_wdata);
        ctrl_in.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_in;
        end
    end

    qec_match #(.NUM_LANES(NUM_LANES)) u_match (
        .ctrl     (ctrl_q),
        .loc_vld  (loc_vld),
        .loc_code (loc_code),
        .loc_mask (loc_mask),
        .sib_vld  (sib_vld),
        .sib_code (sib_code),
        .sib_mask (sib_mask),
        .n_sel    (n_sel)
    );

    qec_qualify #(.NUM_LANES(NUM_LANES)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .priv_lvl (priv_lvl),
        .n_sel    (n_sel),
        .inc      (inc)
    );

    qec_accum #(.CNT_W(CNT_W), .INC_W(N_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cnt_we),
        .wr_data (cnt_wdata),
        .inc     (inc),
        .count   (cnt_rdata),
        .ovf     (ovf_flag)
    );

    assign ctrl_rdata = ctrl_q;
    assign irq        = ovf_flag && ctrl_q.int_en;

    a_r8_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && !ctrl_q.enable) |=> $stable(cnt_rdata));

    a_r6_priv_block: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && !ctrl_q.kern_en && !ctrl_q.user_en) |=> $stable(cnt_rdata));

    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_rdata[23] == 1'b0));

endmodule

// File: tb/qual_evt_counter_tb.sv
module qual_evt_counter_tb;

    localparam int L = 4;
    localparam int CW = 48;
    localparam logic [7:0] CODE = 8'h5A;
    localparam logic [7:0] SMASK = 8'h1E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [L-1:0] loc_vld = '0, sib_vld = '0;
    logic [L*8-1:0] loc_code = '0, loc_mask = '0, sib_code = '0, sib_mask = '0;
    logic [1:0] priv_lvl = 2'd0;
    logic [CW-1:0] cnt_rdata;
    logic [31:0] ctrl_rdata;
    logic ovf_flag, irq;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    qual_evt_counter u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .loc_vld(loc_vld), .loc_code(loc_code), .loc_mask(loc_mask),
        .sib_vld(sib_vld), .sib_code(sib_code), .sib_mask(sib_mask),
        .priv_lvl(priv_lvl), .cnt_rdata(cnt_rdata), .ctrl_rdata(ctrl_rdata),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int th, input bit inv, input bit en,
                                            input bit ie, input bit any, input bit edg,
                                            input bit kern, input bit usr);
        logic [31:0] c;
        c = '0;
        c[7:0]   = CODE;
        c[15:8]  = SMASK;
        c[16]    = usr;
        c[17]    = kern;
        c[18]    = edg;
        c[19]    = any;
        c[20]    = ie;
        c[21]    = en;
        c[22]    = inv;
        c[31:24] = 8'(th);
        return c;
    endfunction

    function automatic int pop4(input logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    // Drive one side's lanes: matching where p is set, otherwise a miss of varied kind.
    task automatic drive_lanes(input bit sib, input logic [3:0] p);
        logic [L-1:0] v;
        logic [L*8-1:0] c, m;
        for (int i = 0; i < L; i++) begin
            if (p[i]) begin
                v[i] = 1'b1; c[i*8 +: 8] = CODE; m[i*8 +: 8] = 8'(1 << (i + 1));
            end else begin
                case (i % 3)
                    0: begin v[i] = 1'b0; c[i*8 +: 8] = CODE;  m[i*8 +: 8] = 8'h02; end
                    1: begin v[i] = 1'b1; c[i*8 +: 8] = 8'hA5; m[i*8 +: 8] = 8'h04; end
                    default: begin v[i] = 1'b1; c[i*8 +: 8] = CODE; m[i*8 +: 8] = 8'hE1; end
                endcase
            end
        end
        if (sib) begin sib_vld = v; sib_code = c; sib_mask = m; end
        else     begin loc_vld = v; loc_code = c; loc_mask = m; end
    endtask

    task automatic idle();
        drive_lanes(1'b0, 4'h0);
        drive_lanes(1'b1, 4'h0);
    endtask

    // Write control and clear count in one cycle.
    task automatic setup(input logic [31:0] c);
        idle();
        ctrl_we = 1'b1; ctrl_wdata = c;
        cnt_we = 1'b1;  cnt_wdata = '0;
        @(negedge clk);
        ctrl_we = 1'b0; cnt_we = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 count", 64'(cnt_rdata), 0);
        check("R12 ovf", 64'(ovf_flag), 0);
        check("R12 irq", 64'(irq), 0);
        check("R12 ctrl", 64'(ctrl_rdata), 0);

        // R11 readback with reserved bit
        ctrl_we = 1'b1; ctrl_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        ctrl_we = 1'b0;
        check("R11 readback", 64'(ctrl_rdata), 64'hFF7F_FFFF);

        // R1..R4 sweep: threshold x invert x local pattern, sibling ignored (R7)
        for (int th = 0; th <= 5; th++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int p = 0; p < 16; p++) begin
                    int n, exp;
                    setup(mk_ctrl(th, inv[0], 1, 0, 0, 0, 1, 1));
                    drive_lanes(1'b0, 4'(p));
                    drive_lanes(1'b1, 4'(~p));
                    @(negedge clk);
                    n = pop4(4'(p));
                    if (th == 0) exp = n;
                    else if (inv != 0) exp = (n < th) ? 1 : 0;
                    else exp = (n >= th) ? 1 : 0;
                    if (th == 0) check("R1 R2 R4 R7 raw", 64'(cnt_rdata), 64'(exp));
                    else if (inv != 0) check("R1 R4 below", 64'(cnt_rdata), 64'(exp));
                    else check("R1 R3 at-or-above", 64'(cnt_rdata), 64'(exp));
                end
            end
        end

        // R7 any-thread sweep
        for (int p = 0; p < 16; p++) begin
            for (int s = 0; s < 16; s++) begin
                setup(mk_ctrl(0, 0, 1, 0, 1, 0, 1, 1));
                drive_lanes(1'b0, 4'(p));
                drive_lanes(1'b1, 4'(s));
                @(negedge clk);
                check("R7 any-thread", 64'(cnt_rdata), 64'(pop4(4'(p | s))));
            end
        end

        // R6 privilege gate
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int k = 0; k < 2; k++) begin
                for (int u = 0; u < 2; u++) begin
                    int exp;
                    setup(mk_ctrl(0, 0, 1, 0, 0, 0, k[0], u[0]));
                    priv_lvl = 2'(lvl);
                    drive_lanes(1'b0, 4'hF);
                    @(negedge clk);
                    exp = ((lvl == 0) ? k : u) != 0 ? 4 : 0;
                    check("R6 privilege", 64'(cnt_rdata), 64'(exp));
                end
            end
        end
        priv_lvl = 2'd0;

        // R5 edge mode
        setup(mk_ctrl(2, 0, 1, 0, 0, 1, 1, 1));
        drive_lanes(1'b0, 4'h7);
        repeat (5) @(negedge clk);
        check("R5 held condition", 64'(cnt_rdata), 1);
        idle();
        repeat (2) @(negedge clk);
        drive_lanes(1'b0, 4'h3);
        repeat (3) @(negedge clk);
        check("R5 re-raised", 64'(cnt_rdata), 2);

        // R8 enable clear
        setup(mk_ctrl(0, 0, 0, 0, 0, 0, 1, 1));
        drive_lanes(1'b0, 4'hF);
        repeat (3) @(negedge clk);
        check("R8 disabled", 64'(cnt_rdata), 0);

        // R9 write priority
        setup(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 1));
        drive_lanes(1'b0, 4'hF);
        cnt_we = 1'b1; cnt_wdata = 48'd100;
        @(negedge clk);
        cnt_we = 1'b0;
        check("R9 write wins", 64'(cnt_rdata), 100);
        @(negedge clk);
        check("R9 count after write", 64'(cnt_rdata), 104);

        // R10 wrap with interrupt enabled
        setup(mk_ctrl(0, 0, 1, 1, 0, 0, 1, 1));
        cnt_we = 1'b1; cnt_wdata = {CW{1'b1}} - 48'd1;
        @(negedge clk);
        cnt_we = 1'b0;
        check("R10 no early ovf", 64'(ovf_flag), 0);
        drive_lanes(1'b0, 4'hF);
        @(negedge clk);
        idle();
        check("R10 wrap value", 64'(cnt_rdata), 2);
        check("R10 ovf set", 64'(ovf_flag), 1);
        check("R10 irq", 64'(irq), 1);
        repeat (2) @(negedge clk);
        check("R10 ovf sticky", 64'(ovf_flag), 1);
        cnt_we = 1'b1; cnt_wdata = 48'd5;
        @(negedge clk);
        cnt_we = 1'b0;
        check("R9 write clears ovf", 64'(ovf_flag), 0);
        check("R10 irq drops", 64'(irq), 0);

        // R10 wrap with interrupt disabled
        setup(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 1));
        cnt_we = 1'b1; cnt_wdata = {CW{1'b1}};
        @(negedge clk);
        cnt_we = 1'b0;
        drive_lanes(1'b0, 4'h1);
        @(negedge clk);
        idle();
        check("R10 wrap to zero", 64'(cnt_rdata), 0);
        check("R10 ovf no ie", 64'(ovf_flag), 1);
        check("R10 irq masked", 64'(irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule